// File: doc/BRIEF.md
# Serial Bit-Rate and Periodic Timer Strobe Generator

This block derives every timing strobe that a serial transceiver needs from the single core clock. It does not produce any derived clock. The core clock is halved first. An optional divide-by-8 prescaler follows, then a 12-bit programmable divider that divides by `cd_val + 1`, then another halving stage. The result is a base strobe. In asynchronous operation the base strobe runs at sixteen times the bit rate and serves as the receiver's oversampling tick. In synchronous operation it runs at twice the bit rate. A mode-dependent post-divider turns the base strobe into the bit strobe and into a square-wave serial clock pin output of selectable polarity.

The same base strobe drives a periodic timer. Its time-out occurs on every base strobe when the fast-timer control is set, and on every sixteenth base strobe when it is clear. When the timer interrupt enable is high, each time-out sets a pending interrupt flag. The flag stays set until the acknowledge input is raised.

All strobes are exactly one core-clock cycle wide. The block has no data stream, so there is no valid/ready interface and no back-pressure. All pins are plain control and status signals. A new divide value or prescaler selection does not take effect immediately. It is loaded at the divider's next terminal count, so a period in progress is never cut short.

Top module: `serial_rate_gen`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `os_tick`, `bit_tick` and `tmr_irq` are 0, and `sclk_out` equals `clk_invert`.
- R2: With `pre_x8` = 0, `os_tick` pulses every 4·(`cd_val`+1) core cycles.
- R3: With `pre_x8` = 1, `os_tick` pulses every 32·(`cd_val`+1) core cycles.
- R4: With `sync_mode` = 0 (asynchronous), `bit_tick` pulses every 16 `os_tick` periods, and always in the same cycle as an `os_tick` pulse.
- R5: With `sync_mode` = 1, `bit_tick` pulses every 2 `os_tick` periods.
- R6: `sclk_out` is a square wave with the same period as `bit_tick`. It is inverted when `clk_invert` = 1.
- R7: The timer time-out period is one `os_tick` period when `tmr_fast` = 1 and 16 `os_tick` periods when `tmr_fast` = 0. With `tmr_irq_en` = 1, each time-out sets `tmr_irq` one cycle later.
- R8: With `tmr_irq_en` = 0, `tmr_irq` never becomes 1.
- R9: A pending `tmr_irq` stays 1 until `tmr_ack` is sampled high. It is then 0 in the next cycle, unless a new time-out occurs in that same cycle, in which case the set wins.
- R10: A change of `cd_val` or `pre_x8` is adopted at the next terminal count of the 12-bit divider. After that, `os_tick` runs at the new period.
- R11: `cd_val` = 0xFFF with `pre_x8` = 0 gives the longest unprescaled `os_tick` period, 16384 cycles.
- R12: Every `os_tick` and `bit_tick` pulse is one core-clock cycle wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| cd_val | input | 12 | Divider value; the divider divides by cd_val+1 |
| pre_x8 | input | 1 | 1 selects the divide-by-8 prescaler, 0 bypasses it |
| sync_mode | input | 1 | 1 selects synchronous post-division (by 2), 0 selects asynchronous (by 16) |
| tmr_fast | input | 1 | 1 bypasses the timer's divide-by-16 stage |
| tmr_irq_en | input | 1 | Timer interrupt enable |
| clk_invert | input | 1 | Serial clock output polarity; 1 inverts |
| tmr_ack | input | 1 | Interrupt acknowledge; clears the pending flag |
| os_tick | output | 1 | Base strobe (16x bit rate in asynchronous mode) |
| bit_tick | output | 1 | Bit-rate strobe for transmitter and receiver |
| sclk_out | output | 1 | Serial clock pin, square wave at the bit rate |
| tmr_irq | output | 1 | Pending timer interrupt |

## Verification
A prescaler or divider count that is off by even one count changes the spacing of `os_tick`. Every interval measured on the base strobe would then be wrong, and the error would be visible within one or two base periods. A fault in the post-divider appears as a wrong `bit_tick` spacing or a wrong `sclk_out` period within two bit periods. A fault in the timer path or the pending flag appears as a wrong spacing between interrupt rises, as a flag that drops without acknowledge, or as a flag that rises while disabled. A divider shadow value that is adopted at the wrong moment shows up as an `os_tick` period that has not settled to the new value one full period after the change.

// File: rtl/rate_pkg.sv
package rate_pkg;
  localparam int CD_W      = 12;
  localparam int PRE_RATIO = 8;
  localparam int OVS       = 16;
  localparam int PRE_W     = $clog2(PRE_RATIO);
  localparam int OVS_W     = $clog2(OVS);

  typedef enum logic {
    MODE_ASYNC = 1'b0,
    MODE_SYNC  = 1'b1
  } xfer_mode_e;
endpackage

// File: rtl/rate_prescale.sv
module rate_prescale
  import rate_pkg::*;
#(
  parameter int RATIO = PRE_RATIO
) (
  input  logic clk,
  input  logic rst,
  input  logic use_pre,
  output logic en_pre
);
  localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

  logic          half_q;
  logic [CW-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (rst) half_q <= 1'b0;
    else     half_q <= ~half_q;
  end

  always_ff @(posedge clk) begin
    if (rst || !use_pre) pcnt <= '0;
    else if (half_q)     pcnt <= (pcnt == LAST) ? '0 : pcnt + 1'b1;
  end

  assign en_pre = half_q && (!use_pre || pcnt == LAST);

  assert_pre_gap_R2: assert property (@(posedge clk) disable iff (rst)
    en_pre |=> !en_pre);
endmodule

// File: rtl/rate_divider.sv
module rate_divider
  import rate_pkg::*;
#(
  parameter int W = CD_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_pre,
  input  logic [W-1:0] cd_in,
  input  logic         pre_in,
  output logic         pre_sh,
  output logic         en_base
);
  logic [W-1:0] cd_sh;
  logic [W-1:0] cnt;
  logic         tog;
  logic         armed;
  logic         en_cd;

  assign en_cd   = en_pre && (cnt == cd_sh);
  assign en_base = en_cd && tog;

  always_ff @(posedge clk) begin
    if (rst) begin
      cd_sh  <= cd_in;
      pre_sh <= pre_in;
      cnt    <= '0;
      tog    <= 1'b0;
      armed  <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (en_pre) cnt <= (cnt == cd_sh) ? '0 : cnt + 1'b1;
      if (en_cd) begin
        tog    <= ~tog;
        cd_sh  <= cd_in;
        pre_sh <= pre_in;
      end
    end
  end

  assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (rst)
    cnt <= cd_sh);
  assert_reload_at_terminal_R10: assert property (@(posedge clk) disable iff (rst || !armed)
    !$stable(cd_sh) |-> $past(en_cd));
endmodule

// File: rtl/rate_post.sv
module rate_post
  import rate_pkg::*;
#(
  parameter int DIV = OVS
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en_base,
  input  xfer_mode_e mode,
  input  logic       fast,
  input  logic       invert,
  output logic       os_tick,
  output logic       bit_tick,
  output logic       sclk,
  output logic       tmo
);
  localparam int OW = $clog2(DIV);
  localparam logic [OW-1:0] LAST = OW'(DIV - 1);

  logic [OW-1:0] ocnt;
  logic          wrap;
  logic          raw_clk;

  assign wrap = (ocnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      ocnt     <= '0;
      os_tick  <= 1'b0;
      bit_tick <= 1'b0;
      tmo      <= 1'b0;
    end else begin
      if (en_base) ocnt <= ocnt + 1'b1;
      os_tick  <= en_base;
      bit_tick <= en_base && ((mode == MODE_SYNC) ? ocnt[0] : wrap);
      tmo      <= en_base && (fast || wrap);
    end
  end

  assign raw_clk = (mode == MODE_SYNC) ? ocnt[0] : ocnt[OW-1];
  assign sclk    = raw_clk ^ invert;

  assert_bit_on_os_R4: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> os_tick);
  assert_os_width_R12: assert property (@(posedge clk) disable iff (rst)
    os_tick |=> !os_tick);
  assert_bit_width_R12: assert property (@(posedge clk) disable iff (rst)
    bit_tick |=> !bit_tick);
endmodule

// File: rtl/serial_rate_gen.sv
module serial_rate_gen
  import rate_pkg::*;
#(
  parameter int DIV_W = CD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] cd_val,
  input  logic             pre_x8,
  input  logic             sync_mode,
  input  logic             tmr_fast,
  input  logic             tmr_irq_en,
  input  logic             clk_invert,
  input  logic             tmr_ack,
  output logic             os_tick,
  output logic             bit_tick,
  output logic             sclk_out,
  output logic             tmr_irq
);
  logic       pre_sh;
  logic       en_pre;
  logic       en_base;
  logic       tmo;
  xfer_mode_e mode;

  assign mode = sync_mode ? MODE_SYNC : MODE_ASYNC;

  rate_prescale #(.RATIO(PRE_RATIO)) u_pre (
    .clk(clk), .rst(rst), .use_pre(pre_sh), .en_pre(en_pre)
  );

  rate_divider #(.W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .en_pre(en_pre), .cd_in(cd_val),
    .pre_in(pre_x8), .pre_sh(pre_sh), .en_base(en_base)
  );

  rate_post #(.DIV(OVS)) u_post (
    .clk(clk), .rst(rst), .en_base(en_base), .mode(mode),
    .fast(tmr_fast), .invert(clk_invert), .os_tick(os_tick),
    .bit_tick(bit_tick), .sclk(sclk_out), .tmo(tmo)
  );

  always_ff @(posedge clk) begin
    if (rst)                   tmr_irq <= 1'b0;
    else if (tmo && tmr_irq_en) tmr_irq <= 1'b1;
    else if (tmr_ack)          tmr_irq <= 1'b0;
  end

  assert_irq_source_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(tmr_irq) && tmr_irq) |-> $past(tmo && tmr_irq_en));
  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (rst)
    !tmr_irq_en |=> !$rose(tmr_irq));
  assert_irq_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (tmr_irq && !tmr_ack) |=> tmr_irq);
  assert_irq_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (tmr_irq && tmr_ack && !tmo) |=> !tmr_irq);
endmodule

// File: tb/serial_rate_gen_test.sv
module serial_rate_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] cd_val = '0;
  logic        pre_x8 = 0, sync_mode = 0, tmr_fast = 0, tmr_irq_en = 0;
  logic        clk_invert = 0, tmr_ack = 0;
  logic        os_tick, bit_tick, sclk_out, tmr_irq;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  serial_rate_gen uut (
    .clk(clk), .rst(rst), .cd_val(cd_val), .pre_x8(pre_x8),
    .sync_mode(sync_mode), .tmr_fast(tmr_fast), .tmr_irq_en(tmr_irq_en),
    .clk_invert(clk_invert), .tmr_ack(tmr_ack), .os_tick(os_tick),
    .bit_tick(bit_tick), .sclk_out(sclk_out), .tmr_irq(tmr_irq)
  );

  typedef struct packed {
    bit        sync;
    bit        pre;
    bit [11:0] cd;
    bit        fast;
    bit        inv;
    int        os_p;
    int        bit_p;
    int        tmr_p;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 12'd3, 1'b0, 1'b0, 16, 256, 256},
    '{1'b0, 1'b1, 12'd2, 1'b1, 1'b1, 96, 1536, 96},
    '{1'b1, 1'b0, 12'd0, 1'b0, 1'b0, 4, 8, 64},
    '{1'b1, 1'b1, 12'd1, 1'b1, 1'b1, 64, 128, 64},
    '{1'b0, 1'b0, 12'd0, 1'b1, 1'b0, 4, 64, 4},
    '{1'b1, 1'b0, 12'd9, 1'b0, 1'b0, 40, 80, 640}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic pick(input int sel);
    case (sel)
      0: return os_tick;
      1: return bit_tick;
      2: return sclk_out;
      default: return tmr_irq;
    endcase
  endfunction

  task automatic measure(input int sel, output int gap);
    logic prev;
    logic cur;
    bit   seen;
    int   cyc;
    gap  = -1;
    seen = 0;
    cyc  = 0;
    @(negedge clk);
    prev = pick(sel);
    for (int n = 0; n < 60000; n++) begin
      @(negedge clk);
      cur = pick(sel);
      if (sel == 3) tmr_ack = cur;
      cyc++;
      if (cur && !prev) begin
        if (seen) begin
          gap = cyc;
          break;
        end
        seen = 1;
        cyc  = 0;
      end
      prev = cur;
    end
    tmr_ack = 0;
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int g;
    int hi;
    // R1: reset state, polarity visible on the pin
    clk_invert = 1;
    repeat (3) @(negedge clk);
    check(os_tick == 0 && bit_tick == 0 && tmr_irq == 0, "R1", os_tick + bit_tick + tmr_irq, 0);
    check(sclk_out == 1, "R1/R6 polarity", sclk_out, 1);
    rst = 0;
    @(negedge clk);
    check(os_tick == 0 && bit_tick == 0 && tmr_irq == 0, "R1 first cycle", os_tick + bit_tick + tmr_irq, 0);

    // table walk: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      sync_mode = VEC[i].sync; pre_x8 = VEC[i].pre; cd_val = VEC[i].cd;
      tmr_fast = VEC[i].fast; clk_invert = VEC[i].inv; tmr_irq_en = 1;
      do_reset();
      measure(0, g);
      check(g == VEC[i].os_p, VEC[i].pre ? "R3 os period" : "R2 os period", g, VEC[i].os_p);
      measure(1, g);
      check(g == VEC[i].bit_p, VEC[i].sync ? "R5 bit period" : "R4 bit period", g, VEC[i].bit_p);
      measure(2, g);
      check(g == VEC[i].bit_p, "R6 sclk period", g, VEC[i].bit_p);
      measure(3, g);
      check(g == VEC[i].tmr_p, "R7 timer period", g, VEC[i].tmr_p);
    end

    // R12: pulse width with the shortest period
    sync_mode = 0; pre_x8 = 0; cd_val = 0; tmr_fast = 0; clk_invert = 0; tmr_irq_en = 0;
    do_reset();
    hi = 0;
    for (int n = 0; n < 200; n++) begin
      @(negedge clk);
      if (os_tick) begin
        @(negedge clk);
        if (os_tick) hi++;
      end
    end
    check(hi == 0, "R12 os width", hi, 0);

    // R8: masked timer never raises the flag
    tmr_fast = 1;
    hi = 0;
    for (int n = 0; n < 300; n++) begin
      @(negedge clk);
      if (tmr_irq) hi++;
    end
    check(hi == 0, "R8 masked irq", hi, 0);

    // R9: pending flag holds without ack, clears on ack
    tmr_fast = 0; tmr_irq_en = 1;
    do_reset();
    for (int n = 0; n < 500; n++) begin
      @(negedge clk);
      if (tmr_irq) break;
    end
    repeat (100) @(negedge clk);
    check(tmr_irq == 1, "R9 hold", tmr_irq, 1);
    tmr_ack = 1;
    @(negedge clk);
    tmr_ack = 0;
    check(tmr_irq == 0, "R9 clear", tmr_irq, 0);

    // R10: new divide value adopted at the next terminal count
    tmr_irq_en = 0; cd_val = 3;
    do_reset();
    repeat (37) @(negedge clk);
    cd_val = 7;
    measure(0, g);
    measure(0, g);
    check(g == 32, "R10 reload", g, 32);
    pre_x8 = 1;
    measure(0, g);
    measure(0, g);
    check(g == 256, "R10 prescale reload", g, 256);

    // R11: maximum divide value
    pre_x8 = 0; cd_val = 12'hFFF;
    do_reset();
    measure(0, g);
    check(g == 16384, "R11 max divider", g, 16384);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule